// File: doc/BRIEF.md
# Serial Mode-Control Register File for a Dual-Channel Converter Back End

This block is a serial programming slave. It lets a host set up the digital output path of a data converter with a four-wire serial port: active-low chip select, serial clock, data in and data out. Each transfer is a fixed 16-bit frame, sent most significant bit first. The first bit chooses read (1) or write (0). The next seven bits give a register address. The last eight bits carry the data. On a read, the addressed register is returned on the data-out pin.

The pins are asynchronous to the system clock. They are brought into the system clock domain and their edges are found there, so the serial clock must run several times slower than the system clock. A write takes effect only when chip select rises after a complete frame. The stored fields drive the output serialization mode, the output-disable control, the line termination enable, the line driver current code and the data randomizer enable. A dedicated reset bit returns every register to zero and emits a single-cycle reset pulse.

Top module: `mcr_spi_regfile`

## Requirements
- R1: After a synchronous reset every register reads 00h. ser_mode, out_off, term_en, lvds_cur, rand_en, soft_rst and sdo are all 0.
- R2: A write frame (first bit 0, then a 7-bit address, then 8 data bits, all MSB first) to address 02h stores the data. The stored data drives ser_mode from bits 2:0, out_off from bit 3, term_en from bit 4 and the current code from bits 7:5.
- R3: Address 01h stores all 8 bits and reads them back. Its bit 0 drives rand_en.
- R4: If the stored current code is the reserved value 011, lvds_cur shows 000. Readback still returns the stored value unchanged.
- R5: If chip select rises before the 16th rising edge of the serial clock, the frame is dropped and no register changes.
- R6: Only the first 16 rising edges of the serial clock in a transfer sample data. Any further edges are ignored, and the frame still commits when chip select rises.
- R7: In a read frame (first bit 1), the addressed register is driven on sdo MSB first. The first bit is driven on the falling edge after the 8th rising edge, and one more bit follows on each later falling edge, so the host samples bits on rising edges 9 to 16. A read changes no register.
- R8: sdo is low whenever a read's data phase is not in progress: during the header, during write frames, after the 16th bit, and while chip select is high.
- R9: A write to address 00h with data bit 7 set clears every register to 00h and drives soft_rst high for exactly one clock cycle. A write to 00h with bit 7 clear does nothing.
- R10: Writes to addresses other than 01h and 02h change nothing. Reads of any address other than 01h and 02h return 00h, and that includes 00h itself.
- R11: Raising chip select always clears the bit position, so the next transfer starts at bit 1, even after an aborted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial readback data to the host |
| ser_mode | output | 3 | Output serialization mode select |
| out_off | output | 1 | Output drivers disabled |
| term_en | output | 1 | Internal line termination enabled |
| lvds_cur | output | 3 | Line driver current code, reserved code shown as 000 |
| rand_en | output | 1 | Output data randomizer enabled |
| soft_rst | output | 1 | One-cycle software reset pulse |

## Verification
A wrong bit counter or wrong shift alignment shows up at once, in the first frame after it goes wrong. The symptoms are a field landing in the wrong output bits, an aborted or overlong frame still changing a register, or readback data moved by one position on sdo. A wrong stored value stays hidden until the next read of that address, or is seen at the decoded outputs a few clocks after chip select rises. For this reason every write in the sweeps is followed straight away by a read and a check of the fields. A stuck reset pulse or a missed register clear is visible within one clock of the committing chip-select edge.

// File: rtl/mcr_pkg.sv
// Shared frame geometry and register addresses for the mode-control register file.
package mcr_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int NUM_REGS   = 3;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_RAND  = 1;
    localparam int ADDR_OUTM  = 2;
    localparam int RST_BIT    = 7;
    localparam int RAND_BIT   = 0;
    localparam logic [2:0] CUR_RSVD = 3'b011;
endpackage

// File: rtl/mcr_pin_sync.sv
// Brings asynchronous pins into the clk domain through a flop chain.
// It also keeps one extra stage, so callers can find edges.
// Assumes: each pin stays stable for several clk periods between changes.
module mcr_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prev
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [STAGES:0] chain;
        // Shift the pin through the synchronizer and the edge-history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {(STAGES + 1){RST_VAL[g]}};
            else        chain <= {chain[STAGES-1:0], pins_in[g]};
        end
        assign lvl[g]  = chain[STAGES-1];
        assign prev[g] = chain[STAGES];
    end
endmodule

// File: rtl/mcr_frame_rx.sv
// Assembles a serial frame from synchronized pin levels.
// It reports a write on chip-select release and exposes the header for reads.
// Assumes: the serial clock idles low and data is sampled on its rising edge.
module mcr_frame_rx #(
    parameter int FRAME_BITS = mcr_pkg::FRAME_BITS,
    parameter int ADDR_W     = mcr_pkg::ADDR_W,
    parameter int DATA_W     = mcr_pkg::DATA_W,
    localparam int HDR_BITS  = 1 + ADDR_W,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_prev,
    input  logic              sck_lvl,
    input  logic              sck_prev,
    input  logic              sdi_lvl,
    output logic              active,
    output logic              sck_fall,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              at_hdr,
    output logic              hdr_is_read,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [FRAME_BITS-1:0] shreg;
    logic sck_rise, cs_rise;

    assign active   = !cs_lvl;
    assign sck_rise = sck_lvl && !sck_prev;
    assign sck_fall = !sck_lvl && sck_prev;
    assign cs_rise  = cs_lvl && !cs_prev;

    // Shift in one bit on each of the first FRAME_BITS rising edges, and clear between transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!active) begin
            bit_cnt <= '0;
        end else if (sck_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
            shreg   <= {shreg[FRAME_BITS-2:0], sdi_lvl};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign at_hdr      = (bit_cnt == CNT_W'(HDR_BITS));
    assign hdr_is_read = shreg[ADDR_W];
    assign hdr_addr    = shreg[ADDR_W-1:0];
    assign wr_addr     = shreg[FRAME_BITS-2 -: ADDR_W];
    assign wr_data     = shreg[DATA_W-1:0];
    assign wr_stb      = cs_rise && (bit_cnt == CNT_W'(FRAME_BITS)) && !shreg[FRAME_BITS-1];
endmodule

// File: rtl/mcr_sdo_shift.sv
// Drives the readback byte on sdo, one bit per falling serial-clock edge.
// Assumes: the read data for the header address is valid at the header boundary.
module mcr_sdo_shift #(
    parameter int FRAME_BITS = mcr_pkg::FRAME_BITS,
    parameter int DATA_W     = mcr_pkg::DATA_W,
    parameter int HDR_BITS   = mcr_pkg::HDR_BITS,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_fall,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              at_hdr,
    input  logic              hdr_is_read,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo
);
    logic [DATA_W-1:0] txbuf;
    logic              rd_on;

    // Load at the header boundary, shift during the data phase, and hold sdo low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sdo   <= 1'b0;
            txbuf <= '0;
            rd_on <= 1'b0;
        end else if (sck_fall) begin
            if (at_hdr && hdr_is_read) begin
                sdo   <= rd_data[DATA_W-1];
                txbuf <= {rd_data[DATA_W-2:0], 1'b0};
                rd_on <= 1'b1;
            end else if (rd_on && bit_cnt > CNT_W'(HDR_BITS) && bit_cnt < CNT_W'(FRAME_BITS)) begin
                sdo   <= txbuf[DATA_W-1];
                txbuf <= {txbuf[DATA_W-2:0], 1'b0};
            end else begin
                sdo   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mcr_regbank.sv
// Holds the mode registers, handles the software reset and muxes readback.
// Address 0 is write-only: its reset bit clears itself.
// Assumes: wr_stb is a single-cycle strobe.
module mcr_regbank #(
    parameter int NUM_REGS  = mcr_pkg::NUM_REGS,
    parameter int ADDR_W    = mcr_pkg::ADDR_W,
    parameter int DATA_W    = mcr_pkg::DATA_W,
    parameter int RST_BIT   = mcr_pkg::RST_BIT,
    parameter int RAND_ADDR = mcr_pkg::ADDR_RAND,
    parameter int RAND_BIT  = mcr_pkg::RAND_BIT,
    parameter int OUTM_ADDR = mcr_pkg::ADDR_OUTM,
    parameter int CTRL_ADDR = mcr_pkg::ADDR_CTRL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] outm_q,
    output logic              rand_q,
    output logic              soft_rst
);
    logic [DATA_W-1:0] store [NUM_REGS];
    logic              clear_all;

    assign clear_all = wr_stb && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[RST_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == CTRL_ADDR) begin : g_ctrl
            assign store[g] = '0;
        end else begin : g_mode
            // Store the mode byte on a matching write, and clear it on reset or software reset.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_all)                      store[g] <= '0;
                else if (wr_stb && wr_addr == ADDR_W'(g))     store[g] <= wr_data;
            end
        end
    end

    // Register the software reset so it is one clean cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst <= 1'b0;
        else        soft_rst <= clear_all;
    end

    // Select readback data: unmapped addresses give zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = store[i];
    end

    assign outm_q = store[OUTM_ADDR];
    assign rand_q = store[RAND_ADDR][RAND_BIT];
endmodule

// File: rtl/mcr_spi_regfile.sv
// Top of the serial mode-control register file.
// It synchronizes the pins, receives frames, stores the registers and drives readback.
// Assumes: the serial clock is at least 8 times slower than clk.
module mcr_spi_regfile #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output logic       sdo,
    output logic [2:0] ser_mode,
    output logic       out_off,
    output logic       term_en,
    output logic [2:0] lvds_cur,
    output logic       rand_en,
    output logic       soft_rst
);
    import mcr_pkg::*;

    logic [2:0] pin_lvl, pin_prev;
    logic cs_lvl, active, sck_fall, at_hdr, hdr_is_read, wr_stb, rand_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] hdr_addr, wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data, outm_q;
    logic [2:0]        cur_raw;

    mcr_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
        .clk(clk), .rst_n(rst_n), .pins_in({sdi, sck, cs_n}),
        .lvl(pin_lvl), .prev(pin_prev)
    );

    assign cs_lvl = pin_lvl[0];

    mcr_frame_rx #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(pin_lvl[0]), .cs_prev(pin_prev[0]),
        .sck_lvl(pin_lvl[1]), .sck_prev(pin_prev[1]),
        .sdi_lvl(pin_lvl[2]),
        .active(active), .sck_fall(sck_fall), .bit_cnt(bit_cnt),
        .at_hdr(at_hdr), .hdr_is_read(hdr_is_read), .hdr_addr(hdr_addr),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    mcr_regbank regs_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(hdr_addr), .rd_data(rd_data),
        .outm_q(outm_q), .rand_q(rand_q), .soft_rst(soft_rst)
    );

    mcr_sdo_shift #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W), .HDR_BITS(HDR_BITS)) tx_i (
        .clk(clk), .rst_n(rst_n), .active(active), .sck_fall(sck_fall),
        .bit_cnt(bit_cnt), .at_hdr(at_hdr), .hdr_is_read(hdr_is_read),
        .rd_data(rd_data), .sdo(sdo)
    );

    // Decode the output-mode fields; the reserved current code is shown as the default.
    assign ser_mode = outm_q[2:0];
    assign out_off  = outm_q[3];
    assign term_en  = outm_q[4];
    assign cur_raw  = outm_q[7:5];
    assign lvds_cur = (cur_raw == CUR_RSVD) ? 3'b000 : cur_raw;
    assign rand_en  = rand_q;
endmodule

// File: rtl/mcr_checker.sv
// Temporal checks on the register file, attached to the top by bind.
module mcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_lvl,
    input logic       sdo,
    input logic       wr_stb,
    input logic       soft_rst,
    input logic [8:0] cfg
);
    // R9
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);
    // R9
    rst_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (cfg == 9'd0));
    // R8
    sdo_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !sdo);
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg));
endmodule

bind mcr_spi_regfile mcr_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .sdo(sdo), .wr_stb(wr_stb),
    .soft_rst(soft_rst),
    .cfg({ser_mode, out_off, term_en, lvds_cur, rand_en})
);

// File: tb/mcr_spi_regfile_tb_top.sv
module mcr_spi_regfile_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo, out_off, term_en, rand_en, soft_rst;
    logic [2:0] ser_mode, lvds_cur;
    int checks = 0, fails = 0, sdo_bad = 0, pulse_cnt = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    mcr_spi_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
        .ser_mode(ser_mode), .out_off(out_off), .term_en(term_en),
        .lvds_cur(lvds_cur), .rand_en(rand_en), .soft_rst(soft_rst)
    );

    always @(negedge clk) if (rst_n && soft_rst) pulse_cnt++;

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One transfer of nbits clocks; edges beyond 16 send ones.
    task automatic xfer(input logic [15:0] word, input int nbits, output logic [7:0] rdv);
        rdv = '0;
        cs_n = 1'b0;
        gap(6);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? word[15-i] : 1'b1;
            gap(6);
            if (i >= 8 && i < 16) rdv = {rdv[6:0], sdo};
            else if (sdo) sdo_bad++;
            sck = 1'b1;
            gap(6);
            sck = 1'b0;
        end
        gap(6);
        if (sdo) sdo_bad++;
        if (!word[15] && rdv != 8'h00) sdo_bad++;
        cs_n = 1'b1;
        sdi = 1'b0;
        gap(10);
        if (sdo) sdo_bad++;
    endtask

    task automatic wr(input int a, input int d);
        logic [7:0] dummy;
        xfer({1'b0, 7'(a), 8'(d)}, 16, dummy);
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        xfer({1'b1, 7'(a), 8'h00}, 16, d);
    endtask

    function automatic int exp_cur(input int v);
        int c = (v >> 5) & 7;
        return (c == 3) ? 0 : c;
    endfunction

    task automatic chk_outm(input string req, input int v);
        chk(req, int'(ser_mode), v & 7, "ser_mode");
        chk(req, int'(out_off), (v >> 3) & 1, "out_off");
        chk(req, int'(term_en), (v >> 4) & 1, "term_en");
        chk(req, int'(lvds_cur), exp_cur(v), "lvds_cur");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        gap(5);
        rst_n = 1'b1;
        gap(4);
        // R1 reset state
        chk("R1", int'({ser_mode, out_off, term_en, lvds_cur, rand_en}), 0, "cfg after reset");
        chk("R1", int'(soft_rst), 0, "soft_rst after reset");
        chk("R1", int'(sdo), 0, "sdo after reset");
        rd(2, rv); chk("R1", int'(rv), 0, "reg 02h after reset");

        // R2 and R4: full sweep of the output mode register
        for (int v = 0; v < 256; v++) begin
            wr(2, v);
            chk_outm("R2", v);
            rd(2, rv);
            chk(((v >> 5) == 3) ? "R4" : "R7", int'(rv), v, "reg 02h readback");
        end

        // R3: randomizer register sweep, reg 02h untouched
        for (int v = 0; v < 256; v += 17) begin
            wr(1, v);
            chk("R3", int'(rand_en), v & 1, "rand_en");
            rd(1, rv);
            chk("R3", int'(rv), v, "reg 01h readback");
        end
        chk_outm("R2", 255);

        // R5 aborted frames
        wr(2, 8'h5A);
        xfer({1'b0, 7'd2, 8'hC3}, 10, rv);
        chk_outm("R5", 8'h5A);
        xfer({1'b0, 7'd2, 8'hC3}, 15, rv);
        rd(2, rv); chk("R5", int'(rv), 8'h5A, "reg 02h after aborts");

        // R11 next transfer starts fresh after abort
        xfer({1'b0, 7'd2, 8'hC3}, 5, rv);
        wr(2, 8'h21);
        rd(2, rv); chk("R11", int'(rv), 8'h21, "write after abort");

        // R6 extra edges ignored on write and read
        xfer({1'b0, 7'd2, 8'h96}, 20, rv);
        chk_outm("R6", 8'h96);
        xfer({1'b1, 7'd2, 8'h00}, 24, rv);
        chk("R6", int'(rv), 8'h96, "read with extra edges");

        // R7 read has no side effect
        rd(2, rv); rd(2, rv);
        chk("R7", int'(rv), 8'h96, "second read");

        // R10 unmapped addresses
        wr(1, 8'h01);
        wr(5, 8'hFF);
        wr(7'h7F, 8'hFF);
        rd(5, rv); chk("R10", int'(rv), 0, "read 05h");
        rd(7'h7F, rv); chk("R10", int'(rv), 0, "read 7Fh");
        rd(0, rv); chk("R10", int'(rv), 0, "read 00h");
        rd(1, rv); chk("R10", int'(rv), 1, "reg 01h intact");
        rd(2, rv); chk("R10", int'(rv), 8'h96, "reg 02h intact");

        // R9 software reset
        wr(1, 8'hAB); wr(2, 8'h3C);
        pulse_cnt = 0;
        wr(0, 8'h7F);
        chk("R9", pulse_cnt, 0, "no pulse without bit 7");
        rd(2, rv); chk("R9", int'(rv), 8'h3C, "reg 02h kept");
        wr(0, 8'h80);
        chk("R9", pulse_cnt, 1, "pulse cycles");
        chk("R9", int'({ser_mode, out_off, term_en, lvds_cur, rand_en}), 0, "cfg cleared");
        rd(1, rv); chk("R9", int'(rv), 0, "reg 01h cleared");
        rd(2, rv); chk("R9", int'(rv), 0, "reg 02h cleared");

        // R8 sdo idle behaviour across all transfers
        chk("R8", sdo_bad, 0, "sdo high outside read data phase");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule